// File: doc/BRIEF.md
# CCD Pixel Timing Generator

This block produces the per-pixel timing for an analog front end that digitizes a CCD output. A single fast system clock drives a phase counter. The counter divides each pixel period into equal ticks. From those ticks the block builds three outputs: a conversion clock with equal high and low halves, a reset-level sampling pulse inside the high half, and a video-level sampling pulse inside the low half. Every edge sits on a fixed tick index. With the default parameters a 20 MHz system clock gives a 1 MHz conversion clock, and each tick is 50 ns.

A pixel counter runs alongside the phase counter and wraps at a line length given on an input. A clamp output marks the unused black pixels at a programmable place in the line. That place is set by a start pixel and a window length, both given on inputs. All outputs come straight from registers, so they cannot glitch.

Top module: `ccdPixelTiming`

## Requirements
- R1: The conversion clock `convClk` repeats every PERIOD_TICKS (default 20) system clocks. Within a period, at phase index p (0 at the rising edge), it is high for p in 0..PERIOD_TICKS/2-1 and low otherwise.
- R2: `sampA` is high only at phase indices SA_RISE to SA_FALL-1 (default 6 and 7, i.e. 300 ns to 400 ns). This places it wholly inside the high half of `convClk`.
- R3: `sampB` is high only at phase indices SB_RISE to SB_FALL-1 (default 16 and 17, i.e. 800 ns to 900 ns). This places it wholly inside the low half of `convClk`. `sampA` and `sampB` are never high together.
- R4: The pixel index starts at 0 after reset and goes up by one at each rising edge of `convClk`. When it would reach `lineLen`, it returns to 0 instead. A `lineLen` of 0 or 1 keeps the index at 0.
- R5: `clampOut` is high for a whole pixel period exactly when that pixel index n satisfies `clampStart` <= n < `clampStart` + `clampLen`. The sum is taken without truncation. `clampOut` changes only together with a rising edge of `convClk`.
- R6: While `rst` is high, at the next clock edge all four outputs go low and both counters clear.
- R7: After `rst` falls, `convClk` rises at the first system clock edge. That edge begins pixel 0 at phase index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (PERIOD_TICKS ticks per pixel) |
| rst | input | 1 | Synchronous reset, active high |
| lineLen | input | PIX_W | Pixels per line; the pixel index wraps at this count |
| clampStart | input | PIX_W | First pixel of the black-pixel clamp window |
| clampLen | input | PIX_W | Number of pixels in the clamp window (0 disables it) |
| convClk | output | 1 | ADC conversion clock |
| sampA | output | 1 | Sampling pulse placed in the high half |
| sampB | output | 1 | Sampling pulse placed in the low half |
| clampOut | output | 1 | Clamp enable during the black-pixel window |

## Verification
The assertions check on every cycle the fixed relations between the outputs. They check that each sampling pulse stays inside its half of the conversion clock, and that the two pulses never overlap. They check that every high half lasts exactly half a period, and that the clamp output moves only on a conversion clock rise. They also check the quiet outputs that reset forces. Only the bench's scenarios can show the exact tick index of each edge, the wrap of the pixel index at different line lengths, and the clamp window landing on the intended pixels. That includes windows that reach past the end of the line and empty windows. The scenarios also cover the position of the first rise after reset, including after a reset that cuts a line short.

// File: rtl/ccdTimingPkg.sv
package ccdTimingPkg;

  // Next-cycle levels decoded by the phase control for the datapath.
  typedef struct packed {
    logic convHi;   // conversion clock level for the coming tick
    logic sampAHi;  // high-half sampling pulse level
    logic sampBHi;  // low-half sampling pulse level
    logic pixStep;  // last tick of the pixel: advance the pixel index
  } phaseStrobes_t;

endpackage

// File: rtl/ccdPhaseCtrl.sv
module ccdPhaseCtrl
  import ccdTimingPkg::*;
#(
  parameter int PERIOD_TICKS = 20,
  parameter int SA_RISE      = 6,
  parameter int SA_FALL      = 8,
  parameter int SB_RISE      = 16,
  parameter int SB_FALL      = 18
) (
  input  logic          clk,
  input  logic          rst,
  output phaseStrobes_t strobes
);

  localparam int HALF_TICKS = PERIOD_TICKS / 2;
  localparam int PH_W       = $clog2(PERIOD_TICKS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD_TICKS - 1);

  logic [PH_W-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
    end else if (phase == PH_LAST) begin
      phase <= '0;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  // Decode the level each output takes for the tick that starts now.
  always_comb begin
    strobes.convHi  = (phase < PH_W'(HALF_TICKS));
    strobes.sampAHi = (phase >= PH_W'(SA_RISE)) && (phase < PH_W'(SA_FALL));
    strobes.sampBHi = (phase >= PH_W'(SB_RISE)) && (phase < PH_W'(SB_FALL));
    strobes.pixStep = (phase == PH_LAST);
  end

endmodule

// File: rtl/ccdPixelPath.sv
module ccdPixelPath
  import ccdTimingPkg::*;
#(
  parameter int PIX_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  phaseStrobes_t    strobes,
  input  logic [PIX_W-1:0] lineLen,
  input  logic [PIX_W-1:0] clampStart,
  input  logic [PIX_W-1:0] clampLen,
  output logic             convClk,
  output logic             sampA,
  output logic             sampB,
  output logic             clampOut
);

  localparam int EXT_W = PIX_W + 1;

  logic [PIX_W-1:0] pixIdx;
  logic [EXT_W-1:0] pixInc;
  logic [EXT_W-1:0] winEnd;
  logic             inWindow;

  always_comb begin
    pixInc   = {1'b0, pixIdx} + EXT_W'(1);
    winEnd   = {1'b0, clampStart} + {1'b0, clampLen};
    inWindow = ({1'b0, pixIdx} >= {1'b0, clampStart}) && ({1'b0, pixIdx} < winEnd);
  end

  // Pixel index moves on the last tick so the clamp, which samples the
  // index held before that edge, lines up with the next conversion rise.
  always_ff @(posedge clk) begin
    if (rst) begin
      pixIdx <= '0;
    end else if (strobes.pixStep) begin
      if (pixInc >= {1'b0, lineLen}) pixIdx <= '0;
      else                           pixIdx <= pixInc[PIX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      convClk  <= 1'b0;
      sampA    <= 1'b0;
      sampB    <= 1'b0;
      clampOut <= 1'b0;
    end else begin
      convClk  <= strobes.convHi;
      sampA    <= strobes.sampAHi;
      sampB    <= strobes.sampBHi;
      clampOut <= inWindow;
    end
  end

endmodule

// File: rtl/ccdPixelTiming.sv
module ccdPixelTiming
  import ccdTimingPkg::*;
#(
  parameter int PIX_W        = 12,
  parameter int PERIOD_TICKS = 20,
  parameter int SA_RISE      = 6,
  parameter int SA_FALL      = 8,
  parameter int SB_RISE      = 16,
  parameter int SB_FALL      = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] lineLen,
  input  logic [PIX_W-1:0] clampStart,
  input  logic [PIX_W-1:0] clampLen,
  output logic             convClk,
  output logic             sampA,
  output logic             sampB,
  output logic             clampOut
);

  phaseStrobes_t strobes;

  ccdPhaseCtrl #(
    .PERIOD_TICKS(PERIOD_TICKS),
    .SA_RISE(SA_RISE), .SA_FALL(SA_FALL),
    .SB_RISE(SB_RISE), .SB_FALL(SB_FALL)
  ) u_ctrl (
    .clk(clk), .rst(rst), .strobes(strobes)
  );

  ccdPixelPath #(.PIX_W(PIX_W)) u_path (
    .clk(clk), .rst(rst), .strobes(strobes),
    .lineLen(lineLen), .clampStart(clampStart), .clampLen(clampLen),
    .convClk(convClk), .sampA(sampA), .sampB(sampB), .clampOut(clampOut)
  );

endmodule

// File: rtl/ccdTimingChecker.sv
module ccdTimingChecker #(
  parameter int PERIOD_TICKS = 20
) (
  input logic clk,
  input logic rst,
  input logic convClk,
  input logic sampA,
  input logic sampB,
  input logic clampOut
);

  localparam int HALF_TICKS = PERIOD_TICKS / 2;

  int hiRun;

  // Counts consecutive high ticks of the conversion clock.
  always_ff @(posedge clk) begin
    if (rst || !convClk) hiRun <= 0;
    else                 hiRun <= hiRun + 1;
  end

  assert_high_half_len_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(convClk) |-> (hiRun == HALF_TICKS));

  assert_sampa_in_high_R2: assert property (@(posedge clk) disable iff (rst)
    sampA |-> convClk);

  assert_sampb_in_low_R3: assert property (@(posedge clk) disable iff (rst)
    sampB |-> !convClk);

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(sampA && sampB));

  assert_clamp_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(clampOut) |-> $rose(convClk));

  assert_reset_quiet_R6: assert property (@(posedge clk)
    rst |=> (!convClk && !sampA && !sampB && !clampOut));

endmodule

bind ccdPixelTiming ccdTimingChecker #(.PERIOD_TICKS(PERIOD_TICKS)) u_chk (
  .clk(clk), .rst(rst), .convClk(convClk), .sampA(sampA),
  .sampB(sampB), .clampOut(clampOut)
);

// File: tb/tb_ccdPixelTiming.sv
module tb_ccdPixelTiming;

  localparam int PIX_W = 12;
  localparam int PER   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PIX_W-1:0] lineLen = 12'd8, clampStart = 12'd2, clampLen = 12'd3;
  logic convClk, sampA, sampB, clampOut;

  int nVec = 0, nFail = 0;
  bit finished = 1'b0;

  ccdPixelTiming dut (
    .clk(clk), .rst(rst), .lineLen(lineLen), .clampStart(clampStart),
    .clampLen(clampLen), .convClk(convClk), .sampA(sampA), .sampB(sampB),
    .clampOut(clampOut)
  );

  always #5 clk = ~clk;

  // Behavioural reference: tick position and pixel number as plain integers.
  int  mTick = 0, mPix = 0;
  bit  armed = 1'b0;
  bit  eConv = 0, eA = 0, eB = 0, eClamp = 0;

  always @(posedge clk) begin
    armed <= 1'b1;
    if (rst) begin
      mTick = 0; mPix = 0;
      eConv = 0; eA = 0; eB = 0; eClamp = 0;
    end else begin
      eConv  = (mTick < PER / 2);
      eA     = (mTick >= 6 && mTick <= 7);
      eB     = (mTick >= 16 && mTick <= 17);
      eClamp = (mPix >= int'(clampStart)) && (mPix < int'(clampStart) + int'(clampLen));
      mTick++;
      if (mTick == PER) begin
        mTick = 0;
        mPix  = (mPix + 1 >= int'(lineLen)) ? 0 : mPix + 1;
      end
    end
  end

  task automatic check(string req, string what, logic act, bit exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (armed && !finished) begin
      check(rst ? "R6" : "R1", "convClk",  convClk,  eConv);
      check(rst ? "R6" : "R2", "sampA",    sampA,    eA);
      check(rst ? "R6" : "R3", "sampB",    sampB,    eB);
      check(rst ? "R6" : "R5", "clampOut", clampOut, eClamp);
    end
  end

  task automatic runScenario(int len, int cs, int cl, int ticks);
    @(negedge clk);
    rst = 1'b1;
    lineLen = PIX_W'(len); clampStart = PIX_W'(cs); clampLen = PIX_W'(cl);
    repeat (3) @(negedge clk);
    // R6: reset holds every output low
    check("R6", "reset convClk", convClk, 1'b0);
    check("R6", "reset clamp",   clampOut, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    // R7: first rise one edge after release, pixel 0 clamp state
    check("R7", "first rise", convClk, 1'b1);
    check("R7", "first sampA", sampA, 1'b0);
    repeat (ticks - 1) @(negedge clk);
  endtask

  initial begin
    // R4/R5: window inside the line, several lines
    runScenario(8, 2, 3, 3 * 8 * PER);
    // R4: short line, clamp on pixel 0 only
    runScenario(5, 0, 1, 3 * 5 * PER);
    // R5: window running past end of line
    runScenario(6, 4, 5, 2 * 6 * PER);
    // R5: empty window
    runScenario(7, 1, 0, 2 * 7 * PER);
    // R6/R7: reset cutting a line short, then restart
    runScenario(9, 3, 2, 4 * PER + 7);
    // R4: line length of 1 keeps pixel 0, clamp on pixel 0
    runScenario(1, 0, 1, 3 * PER);
    // R4: line length 0 behaves like 1
    runScenario(0, 1, 4, 2 * PER);
    // R5: window at the last pixel of a long line
    runScenario(12, 11, 1, 2 * 12 * PER);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

endmodule